// File: doc/BRIEF.md
# Processor Supervisory Reset Controller with Watchdog

This block generates the reset for a processor from three sources: an undervoltage flag from an external comparator, an active-low manual reset pin (a push-button), and a watchdog that software must keep toggling. Any one of these sources asserts the reset. Once the last source is gone, the reset is held for a fixed release period so that the supply and the clocks can settle before code runs.

Timeouts are given in milliseconds and converted to clock cycles through the clock frequency parameter. The manual pin and the watchdog pin are each synchronized through two flops. The manual pin also goes through a low-level persistence filter, so short negative spikes are ignored.

The watchdog counts only while the reset is released. It restarts on every rising or falling edge of its input. A flag turns the watchdog off, which stands in for detecting a floating pin. Two registered outputs drive the processor: one active-low, one active-high.

Top module: `sup_reset_ctl`

## Requirements
- R1: While `uv_flag` is 1 at a rising clock edge, the reset is asserted in the cycle after that edge. The reset releases HOLD_CYC cycles after the last edge at which `uv_flag` was seen high, so a pulse covering L edges gives L+HOLD_CYC-1 asserted cycles.
- R2: A low level on `mrst_n_pin` counts as a manual reset only after the synchronized pin has been sampled low on MR_FILT consecutive edges. A low pulse of L cycles with L < MR_FILT leaves the outputs deasserted.
- R3: An accepted manual pulse of L cycles gives exactly L+HOLD_CYC-MR_FILT asserted cycles. This is two synchronizer stages plus one filter register on each edge of the pin, followed by the release hold.
- R4: With the watchdog enabled and never serviced, the reset reasserts WDOG_CYC+1 cycles after it was released.
- R5: Either a rising or a falling edge on `wdog_pin` restarts the watchdog count. A toggle applied k cycles after release (release cycle = 0) prevents the bite at cycle WDOG_CYC+1 exactly when k <= WDOG_CYC-3.
- R6: A watchdog bite holds the reset for HOLD_CYC cycles.
- R7: The watchdog is cleared and does not count while the reset is asserted. However long a reset lasts, the next bite comes WDOG_CYC+1 cycles after release.
- R8: With `wdog_on` = 0 the watchdog never asserts the reset. Undervoltage and manual reset keep working.
- R9: A cause that appears while the release hold is counting restarts the hold. The release then follows HOLD_CYC cycles after the new cause clears.
- R10: `cpu_rst` is always the complement of `cpu_rst_n`, and both come straight from flops.
- R11: While `rst` is high, `cpu_rst_n` = 0 and `cpu_rst` = 1. With no cause present, the reset releases HOLD_CYC cycles after the last clock edge with `rst` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset of the controller |
| uv_flag | input | 1 | Undervoltage indication from the comparator, 1 = supply low |
| mrst_n_pin | input | 1 | Raw manual reset pin, active low, asynchronous |
| wdog_pin | input | 1 | Watchdog service input; any edge services, asynchronous |
| wdog_on | input | 1 | 1 enables the watchdog, 0 disables it |
| cpu_rst_n | output | 1 | Registered processor reset, active low |
| cpu_rst | output | 1 | Registered processor reset, active high |

## Verification
Each result has its own latency:
- Undervoltage acts one cycle after the edge that sees it.
- A manual pin change reaches the hold logic three cycles later.
- A watchdog toggle clears the count on the third edge after it is driven.
- A bite reaches the outputs one cycle after it is raised.

The bench drives inputs and samples outputs on the falling clock edge. It counts asserted samples over windows wide enough to hold a whole reset pulse, and compares the counts with closed-form expressions in L, MR_FILT, HOLD_CYC and WDOG_CYC. Watchdog checks are indexed from the first released sample, so the service-boundary sweep reads the output at exactly sample WDOG_CYC+1.

// File: rtl/sup_pkg.sv
package sup_pkg;
  // Convert a duration in milliseconds to clock cycles, never below 2.
  function automatic int ms_to_cycles(input longint clk_hz, input longint ms);
    longint c;
    c = (clk_hz * ms) / 1000;
    if (c < 2) c = 2;
    return int'(c);
  endfunction
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {STAGES{RST_VAL}};
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
  parameter int FILT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_s,
  output logic active
);
  localparam int CW = $clog2(FILT + 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run    <= '0;
      active <= 1'b0;
    end else if (pin_n_s) begin
      run    <= '0;
      active <= 1'b0;
    end else if (run == CW'(FILT - 1)) begin
      active <= 1'b1;
    end else begin
      run <= run + 1'b1;
    end
  end

  // R2
  mr_release_chk: assert property (@(posedge clk) disable iff (rst)
    pin_n_s |=> !active);
  // R2
  mr_accept_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> !$past(pin_n_s));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int LIMIT = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic wdi_s,
  input  logic enable,
  input  logic frozen,
  output logic bite
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;
  logic          prev;
  logic          toggled;

  assign toggled = wdi_s ^ prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      prev <= 1'b0;
      bite <= 1'b0;
    end else begin
      prev <= wdi_s;
      bite <= 1'b0;
      if (frozen || !enable || toggled) begin
        cnt <= '0;
      end else if (cnt == CW'(LIMIT - 1)) begin
        cnt  <= '0;
        bite <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R8
  wd_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !bite);
  // R7
  wd_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    frozen |=> !bite);
  // R5
  wd_service_chk: assert property (@(posedge clk) disable iff (rst)
    toggled |=> !bite);
endmodule

// File: rtl/sup_hold.sv
module sup_hold #(
  parameter int HOLD = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,
  output logic rst_o,
  output logic rst_n_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cause) begin
      cnt     <= '0;
      rst_o   <= 1'b1;
      rst_n_o <= 1'b0;
    end else if (rst_o) begin
      if (cnt == CW'(HOLD - 1)) begin
        cnt     <= '0;
        rst_o   <= 1'b0;
        rst_n_o <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R1
  cause_assert_chk: assert property (@(posedge clk) disable iff (rst)
    cause |=> rst_o);
  // R9
  release_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> !$past(cause));
endmodule

// File: rtl/sup_reset_ctl.sv
module sup_reset_ctl #(
  parameter int CLK_HZ  = 125_000_000,
  parameter int HOLD_MS = 140,
  parameter int WDOG_MS = 1600,
  parameter int MR_FILT = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_flag,
  input  logic mrst_n_pin,
  input  logic wdog_pin,
  input  logic wdog_on,
  output logic cpu_rst_n,
  output logic cpu_rst
);
  localparam int HOLD_CYC = sup_pkg::ms_to_cycles(CLK_HZ, HOLD_MS);
  localparam int WDOG_CYC = sup_pkg::ms_to_cycles(CLK_HZ, WDOG_MS);

  logic mr_s, wdi_s, mr_act, wd_bite, cause;

  sup_sync2 #(.STAGES(2), .RST_VAL(1'b1)) u_mr_sync (
    .clk(clk), .rst(rst), .d(mrst_n_pin), .q(mr_s));

  sup_sync2 #(.STAGES(2), .RST_VAL(1'b0)) u_wd_sync (
    .clk(clk), .rst(rst), .d(wdog_pin), .q(wdi_s));

  sup_mr_filter #(.FILT(MR_FILT)) u_mr_filt (
    .clk(clk), .rst(rst), .pin_n_s(mr_s), .active(mr_act));

  sup_wdog #(.LIMIT(WDOG_CYC)) u_wdog (
    .clk(clk), .rst(rst), .wdi_s(wdi_s), .enable(wdog_on),
    .frozen(cpu_rst), .bite(wd_bite));

  assign cause = uv_flag | mr_act | wd_bite;

  sup_hold #(.HOLD(HOLD_CYC)) u_hold (
    .clk(clk), .rst(rst), .cause(cause), .rst_o(cpu_rst), .rst_n_o(cpu_rst_n));

  // R10
  out_complement_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_rst != cpu_rst_n);
  // R4
  bite_reset_chk: assert property (@(posedge clk) disable iff (rst)
    wd_bite |=> cpu_rst);
  // R3
  manual_reset_chk: assert property (@(posedge clk) disable iff (rst)
    mr_act |=> !cpu_rst_n);
endmodule

// File: tb/sup_reset_ctl_test.sv
`timescale 1ns/1ps
module sup_reset_ctl_test;
  localparam int CLK_HZ = 100;
  localparam int HOLD   = (CLK_HZ * 140) / 1000;   // 14
  localparam int WDOG   = (CLK_HZ * 1600) / 1000;  // 160
  localparam int FILT   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uv = 1'b0, mr_n = 1'b1, wdi = 1'b0, wd_en = 1'b0;
  logic rn, rp;
  int checks = 0, fails = 0, lo = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sup_reset_ctl #(.CLK_HZ(CLK_HZ), .HOLD_MS(140), .WDOG_MS(1600), .MR_FILT(FILT)) uut (
    .clk(clk), .rst(rst), .uv_flag(uv), .mrst_n_pin(mr_n), .wdog_pin(wdi),
    .wdog_on(wd_en), .cpu_rst_n(rn), .cpu_rst(rp));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check(rp == !rn, "R10", int'(rp), int'(!rn));
    if (!rn) lo++;
  endtask

  task automatic wait_high();
    for (int i = 0; i < 2000 && !rn; i++) tick();
  endtask

  initial begin
    repeat (3) tick();
    check(rn == 1'b0 && rp == 1'b1, "R11 reset state", int'(rn), 0);
    rst = 1'b0; lo = 0;
    repeat (HOLD + 5) tick();
    check(lo == HOLD - 1, "R11 power-on hold", lo, HOLD - 1);

    // R1 undervoltage pulses of several lengths
    for (int L = 1; L <= 4; L++) begin
      lo = 0; uv = 1'b1;
      tick();
      check(rn == 1'b0, "R1 onset", int'(rn), 0);
      repeat (L - 1) tick();
      uv = 1'b0;
      repeat (HOLD + 5) tick();
      check(lo == L + HOLD - 1, "R1 hold length", lo, L + HOLD - 1);
    end

    // R2 / R3 manual pulse width sweep across the filter threshold
    for (int L = 1; L <= FILT + 3; L++) begin
      int exp;
      exp = (L >= FILT) ? L + HOLD - FILT : 0;
      lo = 0; mr_n = 1'b0;
      repeat (L) tick();
      mr_n = 1'b1;
      repeat (HOLD + 12) tick();
      check(lo == exp, (L >= FILT) ? "R3 manual length" : "R2 glitch ignored", lo, exp);
    end

    // R9 new cause during hold restarts the release count
    lo = 0; uv = 1'b1;
    repeat (2) tick();
    uv = 1'b0;
    repeat (5) tick();
    uv = 1'b1;
    tick();
    uv = 1'b0;
    repeat (HOLD + 5) tick();
    check(lo == 7 + HOLD, "R9 restart", lo, 7 + HOLD);

    // R7 / R4 / R6 long reset, then unserviced watchdog
    wd_en = 1'b1; uv = 1'b1;
    repeat (WDOG + 20) tick();
    uv = 1'b0;
    wait_high();
    repeat (WDOG) tick();
    check(rn == 1'b1, "R7 no early bite", int'(rn), 1);
    tick();
    check(rn == 1'b0, "R4 bite at WDOG+1", int'(rn), 0);
    lo = 0;
    repeat (HOLD + 3) tick();
    check(lo == HOLD - 1, "R6 bite hold", lo, HOLD - 1);

    // R5 service boundary sweep, toggles alternate rising/falling
    for (int k = WDOG - 5; k <= WDOG - 1; k++) begin
      uv = 1'b1; tick(); uv = 1'b0;
      wait_high();
      repeat (k) tick();
      wdi = ~wdi;
      repeat (WDOG + 1 - k) tick();
      check(rn == ((k > WDOG - 3) ? 1'b0 : 1'b1), "R5 service boundary",
            int'(rn), (k > WDOG - 3) ? 0 : 1);
    end

    // R5 sustained servicing keeps reset away
    uv = 1'b1; tick(); uv = 1'b0;
    wait_high();
    lo = 0;
    for (int i = 0; i < 5 * WDOG / 50; i++) begin
      repeat (50) tick();
      wdi = ~wdi;
    end
    check(lo == 0, "R5 sustained service", lo, 0);

    // R8 disabled watchdog
    wd_en = 1'b0;
    uv = 1'b1; tick(); uv = 1'b0;
    wait_high();
    lo = 0;
    repeat (3 * WDOG) tick();
    check(lo == 0, "R8 disabled", lo, 0);
    lo = 0; mr_n = 1'b0;
    repeat (FILT + 2) tick();
    mr_n = 1'b1;
    repeat (HOLD + 12) tick();
    check(lo == HOLD + 2, "R8 manual still works", lo, HOLD + 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule